// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the write-side front end of a NOR-style parallel flash that follows the classic two-unlock command protocol. Every bus write is presented as a single-cycle event with a byte address, a data word and an access width. The decoder follows the multi-write sequences that unlock the part. It recognises identifier (autoselect) entry, single-word program, sector erase, whole-chip erase, the unlock-bypass shortcut and entry to the query table. It reports a read-mode code that the read path uses to choose between array data, identifier words, the query table and status.

Program and erase work is not done here. The decoder emits one-cycle request pulses toward the storage array, each with an aligned address. The array merges program data into the stored word by AND, so a program can only clear bits. The array signals the end of an erase with a completion pulse. Write events are accepted on every cycle and never back-pressured: each one is fully decoded in the cycle it arrives. The request pulses go out as plain strobes with no ready, because the array accepts them unconditionally.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (code 0), bypass is off and neither request pulses.
- R2: A write of 0xAA at unlock address 0 (default word 0x555), then 0x55 at unlock address 1 (default word 0x2AA), then 0xA0 at unlock address 0 sets mode status (code 3). The next write raises prog_req for one cycle in the following cycle, carrying that write's data, its width code and its byte address with the low width bits cleared. Mode then returns to array.
- R3: Any unlock write with the wrong address or the wrong data returns the decoder to read mode, so a later command byte alone has no effect.
- R4: Command byte 0x90 in the third cycle selects identifier mode (code 1). A write of 0x98 to word address 0x55 selects query mode (code 2), from read mode or from identifier mode.
- R5: Any write received in query mode returns the mode to array.
- R6: 0x80 in the third cycle, another unlock pair, then 0x30 at any address raises erase_req with erase_chip low and the address rounded down to a sector boundary. Mode is status until erase_done, and writes other than 0xF0 during the erase are ignored.
- R7: In the sixth cycle, 0x10 at unlock address 0 raises erase_req with erase_chip high and address 0. 0x10 at any other address aborts with no request.
- R8: Data 0xF0 returns the decoder to array mode and clears bypass from every state except the program data cycle, where 0xF0 is programmed like any other data.
- R9: Command byte 0x20 sets bypass. In bypass the decoder waits in the command cycle without unlock writes or address checks, returns there after each program or erase, and leaves bypass on 0x90 followed by 0x00.
- R10: Width code 1 (two bytes) shifts the byte address right by 1 and code 2 (four bytes) by 2 before comparison; codes 0 and 3 use it unshifted. Only the low 11 bits of the result are compared.
- R11: erase_done ends an erase: mode returns to array, into the command cycle when bypass is on.
- R12: An unrecognised byte in the command cycle returns to read mode and clears bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle write event strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; low byte is the command byte |
| wr_width | input | 2 | Access width code: 0 one byte, 1 two bytes, 2 four bytes |
| erase_done | input | 1 | Pulse from the array when an erase finishes |
| mode | output | 2 | Read mode: 0 array, 1 identifier, 2 query, 3 status |
| bypass_on | output | 1 | Unlock bypass active |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Width-aligned program byte address |
| prog_data | output | DATA_W | Program data (array ANDs it into the stored word) |
| prog_width | output | 2 | Width code of the program |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Erase request covers the whole chip |
| erase_addr | output | ADDR_W | Sector-aligned erase byte address, 0 for chip erase |

## Verification
A wrong sequence state is mostly invisible while it lasts. Every unlock stage reports array mode, so a decoder that accepted a bad unlock write shows no difference until a later write completes a command. The bench therefore follows each aborted or reset sequence with the writes that would finish a program, erase or identifier entry if state had survived. It then looks for the stray request pulse or mode change one cycle after that write. Errors in the mode code or the request fields show one cycle after the triggering write, and the scoreboard compares every pulse against the queue of requests the driver expects.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Number of address bits compared against the unlock addresses.
  localparam int UNLK_CMP_W = 11;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,      // read mode, expecting first unlock write
    ST_UNLK2,     // expecting second unlock write
    ST_CMD,       // expecting command byte (bypass idles here)
    ST_PROG,      // expecting program data
    ST_IDENT,     // identifier mode
    ST_E_UNLK1,   // erase setup: first unlock write
    ST_E_UNLK2,   // erase setup: second unlock write
    ST_E_SEL,     // erase setup: chip or sector select
    ST_ERASING,   // erase in progress
    ST_QUERY      // query table mode
  } seq_state_e;

  localparam logic [7:0] BYTE_UNLK_A  = 8'hAA;
  localparam logic [7:0] BYTE_UNLK_B  = 8'h55;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_QUERY   = 8'h98;
  localparam logic [7:0] BYTE_SETUP   = 8'h80;
  localparam logic [7:0] BYTE_IDENT   = 8'h90;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_BYPASS  = 8'h20;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_SECTOR  = 8'h30;
  localparam logic [7:0] BYTE_BYP_END = 8'h00;

  localparam logic [UNLK_CMP_W-1:0] QUERY_WORD = 11'h055;

  function automatic rd_mode_e mode_of(seq_state_e s);
    case (s)
      ST_IDENT:            return MODE_IDENT;
      ST_QUERY:            return MODE_QUERY;
      ST_PROG, ST_ERASING: return MODE_STATUS;
      default:             return MODE_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/fcd_addr_norm.sv
module fcd_addr_norm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]     byte_addr,
  input  logic [1:0]            width,
  output logic [UNLK_CMP_W-1:0] cmp_word,
  output logic [ADDR_W-1:0]     aligned
);
  // Part-selects instead of a shifter: the compared field moves with width.
  always_comb begin
    case (width)
      2'd1: begin
        cmp_word = byte_addr[UNLK_CMP_W:1];
        aligned  = {byte_addr[ADDR_W-1:1], 1'b0};
      end
      2'd2: begin
        cmp_word = byte_addr[UNLK_CMP_W+1:2];
        aligned  = {byte_addr[ADDR_W-1:2], 2'b00};
      end
      default: begin
        cmp_word = byte_addr[UNLK_CMP_W-1:0];
        aligned  = byte_addr;
      end
    endcase
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter logic [UNLK_CMP_W-1:0] UNLOCK0 = 11'h555,
  parameter logic [UNLK_CMP_W-1:0] UNLOCK1 = 11'h2AA
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [7:0]            cmd_byte,
  input  logic [UNLK_CMP_W-1:0] cmp_word,
  input  logic                  erase_done,
  output seq_state_e            state,
  output logic                  bypass,
  output logic                  fire_prog,
  output logic                  fire_sector,
  output logic                  fire_chip
);
  seq_state_e nxt;
  logic       nbyp;
  logic       abort;
  logic       hit_u0, hit_u1, hit_q;

  assign hit_u0 = (cmp_word == UNLOCK0);
  assign hit_u1 = (cmp_word == UNLOCK1);
  assign hit_q  = (cmp_word == QUERY_WORD);

  always_comb begin
    nxt         = state;
    nbyp        = bypass;
    abort       = 1'b0;
    fire_prog   = 1'b0;
    fire_sector = 1'b0;
    fire_chip   = 1'b0;

    if (state == ST_ERASING && erase_done)
      nxt = bypass ? ST_CMD : ST_IDLE;

    if (wr_valid) begin
      if (state != ST_PROG && cmd_byte == BYTE_RESET) begin
        abort = 1'b1;
      end else begin
        case (state)
          ST_IDLE, ST_E_UNLK1: begin
            if (hit_q && cmd_byte == BYTE_QUERY)
              nxt = ST_QUERY;
            else if (hit_u0 && cmd_byte == BYTE_UNLK_A)
              nxt = (state == ST_IDLE) ? ST_UNLK2 : ST_E_UNLK2;
            else
              abort = 1'b1;
          end
          ST_UNLK2, ST_E_UNLK2: begin
            if (hit_u1 && cmd_byte == BYTE_UNLK_B)
              nxt = (state == ST_UNLK2) ? ST_CMD : ST_E_SEL;
            else
              abort = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && !hit_u0) begin
              abort = 1'b1;
            end else begin
              case (cmd_byte)
                BYTE_BYPASS: begin nbyp = 1'b1; nxt = ST_CMD; end
                BYTE_SETUP:  nxt = ST_E_UNLK1;
                BYTE_IDENT:  nxt = ST_IDENT;
                BYTE_PROG:   nxt = ST_PROG;
                default:     abort = 1'b1;
              endcase
            end
          end
          ST_PROG: begin
            fire_prog = 1'b1;
            nxt       = bypass ? ST_CMD : ST_IDLE;
          end
          ST_IDENT: begin
            if (bypass && cmd_byte == BYTE_BYP_END)
              abort = 1'b1;
            else if (hit_q && cmd_byte == BYTE_QUERY)
              nxt = ST_QUERY;
            else
              abort = 1'b1;
          end
          ST_E_SEL: begin
            if (cmd_byte == BYTE_CHIP && hit_u0) begin
              fire_chip = 1'b1;
              nxt       = ST_ERASING;
            end else if (cmd_byte == BYTE_SECTOR) begin
              fire_sector = 1'b1;
              nxt         = ST_ERASING;
            end else begin
              abort = 1'b1;
            end
          end
          ST_ERASING: ;  // writes ignored while erasing
          default:    abort = 1'b1;  // query mode and any stray state
        endcase
      end
    end

    if (abort) begin
      nxt  = ST_IDLE;
      nbyp = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bypass <= 1'b0;
    end else begin
      state  <= nxt;
      bypass <= nbyp;
    end
  end
endmodule

// File: rtl/fcd_req_gen.sv
module fcd_req_gen #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int SECTOR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_prog,
  input  logic              fire_sector,
  input  logic              fire_chip,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        width,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [1:0]        prog_width,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr
);
  localparam logic [ADDR_W-1:0] SECT_MASK =
    ~((ADDR_W'(1) << SECTOR_AW) - ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      prog_width <= '0;
      erase_req  <= 1'b0;
      erase_chip <= 1'b0;
      erase_addr <= '0;
    end else begin
      prog_req  <= fire_prog;
      erase_req <= fire_sector | fire_chip;
      if (fire_prog) begin
        prog_addr  <= word_addr;
        prog_data  <= data;
        prog_width <= width;
      end
      if (fire_sector | fire_chip) begin
        erase_chip <= fire_chip;
        erase_addr <= fire_chip ? '0 : (byte_addr & SECT_MASK);
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int SECTOR_AW = 12,
  parameter logic [UNLK_CMP_W-1:0] UNLOCK0 = 11'h555,
  parameter logic [UNLK_CMP_W-1:0] UNLOCK1 = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_width,
  input  logic              erase_done,
  output logic [1:0]        mode,
  output logic              bypass_on,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [1:0]        prog_width,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr
);
  logic [UNLK_CMP_W-1:0] cmp_word;
  logic [ADDR_W-1:0]     aligned;
  seq_state_e            state;
  logic                  fire_prog, fire_sector, fire_chip;

  fcd_addr_norm #(.ADDR_W(ADDR_W)) u_norm (
    .byte_addr (wr_addr),
    .width     (wr_width),
    .cmp_word  (cmp_word),
    .aligned   (aligned)
  );

  fcd_seq_fsm #(.UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .cmd_byte    (wr_data[7:0]),
    .cmp_word    (cmp_word),
    .erase_done  (erase_done),
    .state       (state),
    .bypass      (bypass_on),
    .fire_prog   (fire_prog),
    .fire_sector (fire_sector),
    .fire_chip   (fire_chip)
  );

  fcd_req_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_AW(SECTOR_AW)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_prog   (fire_prog),
    .fire_sector (fire_sector),
    .fire_chip   (fire_chip),
    .word_addr   (aligned),
    .byte_addr   (wr_addr),
    .data        (wr_data),
    .width       (wr_width),
    .prog_req    (prog_req),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .prog_width  (prog_width),
    .erase_req   (erase_req),
    .erase_chip  (erase_chip),
    .erase_addr  (erase_addr)
  );

  // Mode follows the state register directly, so it changes one cycle after a write.
  assign mode = mode_of(state);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [7:0] cmd_lo,
  input logic [1:0] mode,
  input logic       bypass_on,
  input logic       prog_req,
  input logic       erase_req
);
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));

  p_prog_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  p_prog_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(mode) == 2'd3);

  p_erase_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> mode == 2'd3);

  p_erase_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  p_query_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_valid) |=> mode != 2'd2);

  p_reset_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cmd_lo == 8'hF0 && mode != 2'd3) |=> (mode == 2'd0 && !bypass_on));

  p_bypass_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_on) |-> ($past(wr_valid) && $past(cmd_lo) == 8'h20));
endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .cmd_lo    (wr_data[7:0]),
  .mode      (mode),
  .bypass_on (bypass_on),
  .prog_req  (prog_req),
  .erase_req (erase_req)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    wr_width = 2'd0;
  logic          erase_done = 1'b0;
  logic [1:0]    mode;
  logic          bypass_on, prog_req, erase_req, erase_chip;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [DW-1:0] prog_data;
  logic [1:0]    prog_width;

  always #2 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_width(wr_width), .erase_done(erase_done),
    .mode(mode), .bypass_on(bypass_on), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_width(prog_width),
    .erase_req(erase_req), .erase_chip(erase_chip), .erase_addr(erase_addr)
  );

  typedef struct packed {
    logic          is_erase;
    logic          chip;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    width;
  } req_t;

  req_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic [1:0] exp);
    chk(mode === exp, req, 64'(mode), 64'(exp));
  endtask

  task automatic chk_byp(input string req, input logic exp);
    chk(bypass_on === exp, req, 64'(bypass_on), 64'(exp));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [1:0] w = 2'd0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = DW'(d); wr_width = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_width = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h555, 8'hAA);
    wr(20'h2AA, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic exp_prog(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] w);
    exp_q.push_back('{is_erase: 1'b0, chip: 1'b0, addr: a, data: d, width: w});
    tag_q.push_back(req);
  endtask

  task automatic exp_erase(input string req, input logic chip, input logic [AW-1:0] a);
    exp_q.push_back('{is_erase: 1'b1, chip: chip, addr: a, data: '0, width: 2'd0});
    tag_q.push_back(req);
  endtask

  // Monitor: every request pulse is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rst_n && !done && (prog_req || erase_req)) begin
      req_t act;
      act = prog_req ? '{is_erase: 1'b0, chip: 1'b0, addr: prog_addr, data: prog_data, width: prog_width}
                     : '{is_erase: 1'b1, chip: erase_chip, addr: erase_addr, data: '0, width: 2'd0};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R6 unexpected request actual=%h expected=none", act);
      end else begin
        req_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s request actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_mode("R1 reset mode", 2'd0);
    chk_byp("R1 reset bypass", 1'b0);
    chk(!prog_req && !erase_req, "R1 no request", 64'({prog_req, erase_req}), 64'd0);

    // R2 normal program
    unlock();
    wr(20'h555, 8'hA0);
    chk_mode("R2 status while waiting for data", 2'd3);
    exp_prog("R2", 20'h01234, 32'h0000005A, 2'd0);
    wr(20'h01234, 8'h5A);
    chk_mode("R2 back to array", 2'd0);

    // R3 wrong unlock address, then wrong unlock data
    wr(20'h555, 8'hAA);
    wr(20'h2AB, 8'h55);
    chk_mode("R3 bad address aborts", 2'd0);
    wr(20'h555, 8'hA0);
    wr(20'h00100, 8'h11);
    chk_mode("R3 no program after abort", 2'd0);
    wr(20'h555, 8'hAB);
    wr(20'h2AA, 8'h55);
    wr(20'h555, 8'h90);
    chk_mode("R3 bad data aborts", 2'd0);

    // R4 identifier and query entry; R5 query exit
    unlock();
    wr(20'h555, 8'h90);
    chk_mode("R4 identifier mode", 2'd1);
    wr(20'h055, 8'h98);
    chk_mode("R4 query from identifier", 2'd2);
    wr(20'h00000, 8'h00);
    chk_mode("R5 write in query exits", 2'd0);
    wr(20'h055, 8'h98);
    chk_mode("R4 query from read", 2'd2);
    wr(20'h00123, 8'h77);
    chk_mode("R5 second query exit", 2'd0);

    // R6 sector erase, writes ignored during erase; R11 completion
    unlock(); wr(20'h555, 8'h80); unlock();
    exp_erase("R6", 1'b0, 20'h03000);
    wr(20'h03456, 8'h30);
    chk_mode("R6 status during erase", 2'd3);
    wr(20'h555, 8'hAA);
    wr(20'h02000, 8'h30);
    chk_mode("R6 writes ignored during erase", 2'd3);
    done_pulse();
    chk_mode("R11 erase done returns to array", 2'd0);

    // R7 chip erase, and wrong address for chip erase
    unlock(); wr(20'h555, 8'h80); unlock();
    exp_erase("R7", 1'b1, 20'h00000);
    wr(20'h555, 8'h10);
    chk_mode("R7 status during chip erase", 2'd3);
    done_pulse();
    unlock(); wr(20'h555, 8'h80); unlock();
    wr(20'h554, 8'h10);
    chk_mode("R7 chip erase at wrong address aborts", 2'd0);

    // R8 reset byte
    unlock(); wr(20'h555, 8'h90);
    wr(20'h00000, 8'hF0);
    chk_mode("R8 reset from identifier", 2'd0);
    unlock(); wr(20'h555, 8'h80); wr(20'h555, 8'hAA);
    wr(20'h00000, 8'hF0);
    wr(20'h2AA, 8'h55);
    wr(20'h00100, 8'h30);
    chk_mode("R8 erase setup cleared by reset byte", 2'd0);
    unlock(); wr(20'h555, 8'h80); unlock();
    exp_erase("R8", 1'b0, 20'h05000);
    wr(20'h05001, 8'h30);
    wr(20'h00000, 8'hF0);
    chk_mode("R8 reset byte during erase", 2'd0);
    unlock(); wr(20'h555, 8'hA0);
    exp_prog("R8 reset byte programmed as data", 20'h00040, 32'h000000F0, 2'd0);
    wr(20'h00040, 8'hF0);
    chk_mode("R8 after program of 0xF0", 2'd0);

    // R9 unlock bypass
    unlock(); wr(20'h555, 8'h20);
    chk_byp("R9 bypass set", 1'b1);
    chk_mode("R9 bypass mode array", 2'd0);
    wr(20'h00777, 8'hA0);
    chk_mode("R9 program without unlock", 2'd3);
    exp_prog("R9", 20'h00100, 32'h0000000F, 2'd0);
    wr(20'h00100, 8'h0F);
    chk_byp("R9 bypass kept after program", 1'b1);
    wr(20'h00000, 8'h80); unlock();
    exp_erase("R9 erase in bypass", 1'b0, 20'h07000);
    wr(20'h07ABC, 8'h30);
    done_pulse();
    chk_byp("R11 bypass kept after erase", 1'b1);
    wr(20'h00000, 8'hA0);
    chk_mode("R11 erase done returns to command cycle", 2'd3);
    exp_prog("R11", 20'h00200, 32'h00000033, 2'd0);
    wr(20'h00200, 8'h33);
    wr(20'h00999, 8'h90);
    chk_mode("R9 identifier in bypass", 2'd1);
    wr(20'h00000, 8'h00);
    chk_byp("R9 bypass left", 1'b0);
    wr(20'h00123, 8'hA0);
    chk_mode("R9 unlock needed again", 2'd0);

    // R10 width shifts and 11-bit compare
    wr(20'h00AAA, 8'hAA, 2'd1); wr(20'h00554, 8'h55, 2'd1); wr(20'h00AAA, 8'hA0, 2'd1);
    chk_mode("R10 two-byte unlock", 2'd3);
    exp_prog("R10 two-byte", 20'h02002, 32'h0000BEEF, 2'd1);
    wr_full(20'h02003, 32'h0000BEEF, 2'd1);
    wr(20'h01554, 8'hAA, 2'd2); wr(20'h00AA8, 8'h55, 2'd2); wr(20'h01554, 8'hA0, 2'd2);
    chk_mode("R10 four-byte unlock", 2'd3);
    exp_prog("R10 four-byte", 20'h03004, 32'hCAFE1234, 2'd2);
    wr_full(20'h03007, 32'hCAFE1234, 2'd2);
    wr(20'h00555, 8'hAA, 2'd1); wr(20'h00554, 8'h55, 2'd1); wr(20'h00AAA, 8'h90, 2'd1);
    chk_mode("R10 unshifted address rejected at two-byte width", 2'd0);
    wr(20'h00D55, 8'hAA); wr(20'h00AAA, 8'h55); wr(20'h01555, 8'h90);
    chk_mode("R10 only low 11 bits compared", 2'd1);
    wr(20'h00000, 8'hF0);

    // R12 unknown command byte
    unlock(); wr(20'h555, 8'h77);
    chk_mode("R12 unknown command", 2'd0);
    unlock(); wr(20'h555, 8'h20);
    wr(20'h00010, 8'h77);
    chk_byp("R12 unknown command clears bypass", 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R6 all expected requests issued", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule